// File: doc/BRIEF.md
# Hardwired Instruction-Cycle Control Unit

This block is the sequencer of a small accumulator machine. It holds a two-bit cycle code that names the current phase: fetch, indirect, execute or interrupt. It also holds a time-step counter that numbers the clocks inside that phase. Every control line it drives is a fixed Boolean function of the cycle code, the step, the opcode and a zero flag. On each clock the surrounding datapath performs the one micro-operation, or the one group of conflict-free micro-operations, that those lines enable. The unit never sees data values. It sees only the opcode, the indirect bit, the zero flag and the interrupt inputs.

Three opcodes have execute sequences: add to accumulator, increment-and-skip-if-zero, and branch-and-save-address. Every other opcode finishes execute in one empty step. When the last step of a phase is reached, the unit raises its own step-restart line. On the next edge the counter returns to step 1 and the cycle code moves to the next phase. The interrupt test is made at the end of every execute phase. The datapath supplies the instruction bits through a bypass: while fetch step 3 is active, `ir_opcode` and `ir_indirect` show the word that is being loaded into the instruction register.

Top module: `cyc_ctrl_unit`

## Requirements
- R1: `rst_n` low resets the unit at once. Release is synchronised over two rising edges. Until the second rising edge after `rst_n` rises, `cycle_code` is 00, `tstep` is 1, and all of `ctl` and `alu_fn` are 0.
- R2: Fetch (cycle code 00) takes three steps. Step 1 drives bit 0 (PC to MAR). Step 2 drives bit 1 (memory read), bit 2 (MBR load from the data bus) and bit 3 (PC increment). Step 3 drives bit 4 (MBR to IR) and bit 15 (step restart). The memory read never shares a step with MBR to IR.
- R3: At the end of fetch, `ir_indirect` = 1 selects cycle code 01 (indirect) and 0 selects cycle code 10 (execute).
- R4: Indirect takes three steps. Step 1 drives bit 5 (IR address to MAR). Step 2 drives bits 1 and 2. Step 3 drives bit 6 (MBR to IR address) and bit 15. Execute follows.
- R5: Execute of opcode 001 (add) takes three steps. Step 1 drives bit 5. Step 2 drives bits 1 and 2. Step 3 drives bit 12 (accumulator load) and bit 15, with `alu_fn` = 01 (accumulator plus MBR).
- R6: Execute of opcode 010 (increment and skip) takes four steps. Step 1 drives bit 5. Step 2 drives bits 1 and 2. Step 3 drives bit 13 (MBR from ALU) with `alu_fn` = 10 (MBR plus one). Step 4 drives bit 7 (memory write) and bit 15 with `alu_fn` = 00 (pass MBR), and adds bit 3 when `alu_zero` is 1.
- R7: Execute of opcode 011 (branch and save) takes three steps. Step 1 drives bits 5 and 8 (PC to MBR). Step 2 drives bit 7 and bit 14 (IR address to PC). Step 3 drives bits 3 and 15.
- R8: Execute of any other opcode takes one step that drives only bit 15.
- R9: At the end of execute, the cycle code becomes 11 when `irq_req` and `irq_en` are both 1. Otherwise it becomes 00.
- R10: The interrupt phase takes two steps and then returns to fetch. Step 1 drives bit 8, bit 9 (save address to MAR) and bit 10 (handler address to PC). Step 2 drives bit 7, bit 11 (interrupt-enable clear) and bit 15.
- R11: `tstep` rises by one on every clock. After a step in which bit 15 is driven, it returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_opcode | input | 3 | Opcode bits of the instruction register (bypassed during fetch step 3) |
| ir_indirect | input | 1 | Indirect-address bit of the instruction register (bypassed during fetch step 3) |
| alu_zero | input | 1 | ALU result is zero |
| irq_req | input | 1 | Interrupt request |
| irq_en | input | 1 | Interrupt enable held in the datapath |
| cycle_code | output | 2 | Current phase: 00 fetch, 01 indirect, 10 execute, 11 interrupt |
| tstep | output | 3 | Current time step, starting at 1 |
| ctl | output | 16 | Control lines, bit map as in the requirements |
| alu_fn | output | 2 | ALU select: 00 pass MBR, 01 add, 10 increment |

## Verification
`ctl` and `alu_fn` are decoded without a register from the phase and step registers and the live inputs. The control word of a step is therefore valid for the whole clock period in which that step is shown. A phase change or a step restart appears on `cycle_code` and `tstep` one rising edge after the step that drove bit 15. After `rst_n` rises, the first live control word appears after the second rising edge. The bench compares all four outputs at every falling edge against a reference model. That model keeps a queue with one expected word per step for the current phase. A behavioural datapath captures the control lines at that same falling edge and applies them at the next rising edge. As a result, each skip, branch, indirect load and interrupt save can also be checked in memory and register contents after the run.

// File: rtl/cyc_ctrl_pkg.sv
package cyc_ctrl_pkg;

  // Phase encoding carried in the cycle code
  typedef enum logic [1:0] {
    PH_FETCH = 2'b00,
    PH_INDIR = 2'b01,
    PH_EXEC  = 2'b10,
    PH_INTR  = 2'b11
  } phase_t;

  // ALU function select
  typedef enum logic [1:0] {
    ALU_PASS = 2'b00,
    ALU_ADD  = 2'b01,
    ALU_INC  = 2'b10
  } alu_fn_t;

  // Control line positions
  localparam int NUM_CTL         = 16;
  localparam int CL_PC_TO_MAR    = 0;
  localparam int CL_MEM_RD       = 1;
  localparam int CL_MBR_LD       = 2;
  localparam int CL_PC_INC       = 3;
  localparam int CL_MBR_TO_IR    = 4;
  localparam int CL_IRA_TO_MAR   = 5;
  localparam int CL_MBR_TO_IRA   = 6;
  localparam int CL_MEM_WR       = 7;
  localparam int CL_PC_TO_MBR    = 8;
  localparam int CL_SAVE_TO_MAR  = 9;
  localparam int CL_VEC_TO_PC    = 10;
  localparam int CL_CLR_IE       = 11;
  localparam int CL_ACC_LD       = 12;
  localparam int CL_MBR_FROM_ALU = 13;
  localparam int CL_IRA_TO_PC    = 14;
  localparam int CL_STEP_CLR     = 15;

  // Opcodes with their own execute sequence; decoder index = code - 1
  localparam int N_KNOWN_OPS = 3;
  localparam int OPX_ADD     = 0;  // code 1
  localparam int OPX_ISZ     = 1;  // code 2
  localparam int OPX_BSA     = 2;  // code 3

  // Longest sequence length of any phase
  localparam int MAX_STEPS = 4;

endpackage

// File: rtl/cyc_step_ctr.sv
module cyc_step_ctr #(
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              clr_i,
  output logic [STEP_W-1:0] step_o
);

  localparam logic [STEP_W-1:0] STEP_FIRST = STEP_W'(1);

  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] step_d;

  always_comb begin
    if (clr_i) begin
      step_d = STEP_FIRST;
    end else begin
      step_d = step_q + STEP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= STEP_FIRST;
    end else begin
      step_q <= step_d;
    end
  end

  assign step_o = step_q;

endmodule

// File: rtl/cyc_phase_seq.sv
module cyc_phase_seq
  import cyc_ctrl_pkg::*;
(
  input  logic   clk,
  input  logic   rst_ni,
  input  logic   end_i,
  input  logic   ind_i,
  input  logic   irq_req_i,
  input  logic   irq_en_i,
  output phase_t phase_o
);

  phase_t phase_q;
  phase_t phase_d;

  always_comb begin
    phase_d = phase_q;
    if (end_i) begin
      case (phase_q)
        PH_FETCH: phase_d = ind_i ? PH_INDIR : PH_EXEC;
        PH_INDIR: phase_d = PH_EXEC;
        PH_EXEC:  phase_d = (irq_req_i && irq_en_i) ? PH_INTR : PH_FETCH;
        default:  phase_d = PH_FETCH;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_FETCH;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/cyc_ctl_decode.sv
module cyc_ctl_decode
  import cyc_ctrl_pkg::*;
#(
  parameter int OP_W   = 3,
  parameter int STEP_W = 3
) (
  input  phase_t               phase_i,
  input  logic [STEP_W-1:0]    step_i,
  input  logic [OP_W-1:0]      opcode_i,
  input  logic                 zero_i,
  output logic [NUM_CTL-1:0]   ctl_o,
  output alu_fn_t              alu_fn_o
);

  // One decoded line per opcode with its own sequence and per time step
  logic [N_KNOWN_OPS-1:0] op_hot;
  logic [MAX_STEPS-1:0]   t_hot;

  for (genvar k = 0; k < N_KNOWN_OPS; k++) begin : g_op_dec
    assign op_hot[k] = (opcode_i == OP_W'(k + 1));
  end

  for (genvar s = 0; s < MAX_STEPS; s++) begin : g_step_dec
    assign t_hot[s] = (step_i == STEP_W'(s + 1));
  end

  logic p_f, p_i, p_e, p_x;
  logic o_add, o_isz, o_bsa, o_other, o_operand, o_memref;
  logic t1, t2, t3, t4;

  assign p_f = (phase_i == PH_FETCH);
  assign p_i = (phase_i == PH_INDIR);
  assign p_e = (phase_i == PH_EXEC);
  assign p_x = (phase_i == PH_INTR);

  assign o_add     = op_hot[OPX_ADD];
  assign o_isz     = op_hot[OPX_ISZ];
  assign o_bsa     = op_hot[OPX_BSA];
  assign o_other   = ~|op_hot;
  assign o_operand = o_add | o_isz;
  assign o_memref  = o_add | o_isz | o_bsa;

  assign t1 = t_hot[0];
  assign t2 = t_hot[1];
  assign t3 = t_hot[2];
  assign t4 = t_hot[3];

  // Each line is a sum of products over phase, step and opcode
  always_comb begin
    ctl_o = '0;
    ctl_o[CL_PC_TO_MAR]    = p_f & t1;
    ctl_o[CL_MEM_RD]       = ((p_f | p_i) & t2) | (p_e & o_operand & t2);
    ctl_o[CL_MBR_LD]       = ((p_f | p_i) & t2) | (p_e & o_operand & t2);
    ctl_o[CL_PC_INC]       = (p_f & t2) | (p_e & o_bsa & t3)
                           | (p_e & o_isz & t4 & zero_i);
    ctl_o[CL_MBR_TO_IR]    = p_f & t3;
    ctl_o[CL_IRA_TO_MAR]   = (p_i & t1) | (p_e & o_memref & t1);
    ctl_o[CL_MBR_TO_IRA]   = p_i & t3;
    ctl_o[CL_MEM_WR]       = (p_e & o_isz & t4) | (p_e & o_bsa & t2) | (p_x & t2);
    ctl_o[CL_PC_TO_MBR]    = (p_e & o_bsa & t1) | (p_x & t1);
    ctl_o[CL_SAVE_TO_MAR]  = p_x & t1;
    ctl_o[CL_VEC_TO_PC]    = p_x & t1;
    ctl_o[CL_CLR_IE]       = p_x & t2;
    ctl_o[CL_ACC_LD]       = p_e & o_add & t3;
    ctl_o[CL_MBR_FROM_ALU] = p_e & o_isz & t3;
    ctl_o[CL_IRA_TO_PC]    = p_e & o_bsa & t2;
    ctl_o[CL_STEP_CLR]     = ((p_f | p_i) & t3)
                           | (p_e & ((o_add & t3) | (o_isz & t4)
                                    | (o_bsa & t3) | (o_other & t1)))
                           | (p_x & t2);
  end

  always_comb begin
    alu_fn_o = ALU_PASS;
    if (p_e && o_add && t3) begin
      alu_fn_o = ALU_ADD;
    end else if (p_e && o_isz && t3) begin
      alu_fn_o = ALU_INC;
    end
  end

endmodule

// File: rtl/cyc_ctrl_unit.sv
module cyc_ctrl_unit
  import cyc_ctrl_pkg::*;
#(
  parameter int OP_W       = 3,
  parameter int STEP_W     = 3,
  parameter int RST_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [OP_W-1:0]     ir_opcode,
  input  logic                ir_indirect,
  input  logic                alu_zero,
  input  logic                irq_req,
  input  logic                irq_en,
  output logic [1:0]          cycle_code,
  output logic [STEP_W-1:0]   tstep,
  output logic [NUM_CTL-1:0]  ctl,
  output logic [1:0]          alu_fn
);

  // Reset: asserted asynchronously, released after RST_STAGES edges
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
    end
  end

  assign rst_done = rst_pipe[RST_STAGES-1];

  phase_t               phase;
  logic [STEP_W-1:0]    step;
  logic [NUM_CTL-1:0]   ctl_raw;
  alu_fn_t              alu_raw;

  cyc_step_ctr #(
    .STEP_W (STEP_W)
  ) u_step (
    .clk    (clk),
    .rst_ni (rst_done),
    .clr_i  (ctl_raw[CL_STEP_CLR]),
    .step_o (step)
  );

  cyc_phase_seq u_phase (
    .clk       (clk),
    .rst_ni    (rst_done),
    .end_i     (ctl_raw[CL_STEP_CLR]),
    .ind_i     (ir_indirect),
    .irq_req_i (irq_req),
    .irq_en_i  (irq_en),
    .phase_o   (phase)
  );

  cyc_ctl_decode #(
    .OP_W   (OP_W),
    .STEP_W (STEP_W)
  ) u_dec (
    .phase_i  (phase),
    .step_i   (step),
    .opcode_i (ir_opcode),
    .zero_i   (alu_zero),
    .ctl_o    (ctl_raw),
    .alu_fn_o (alu_raw)
  );

  // Datapath is held quiet until the reset release completes
  assign ctl        = rst_done ? ctl_raw : '0;
  assign alu_fn     = rst_done ? alu_raw : ALU_PASS;
  assign cycle_code = phase;
  assign tstep      = step;

endmodule

// File: rtl/cyc_ctrl_chk.sv
module cyc_ctrl_chk #(
  parameter int STEP_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_done,
  input logic              irq_req,
  input logic              irq_en,
  input logic [1:0]        cycle_code,
  input logic [STEP_W-1:0] tstep,
  input logic [1:0]        alu_fn,
  input logic              pc_to_mar,
  input logic              mem_rd,
  input logic              mbr_ld,
  input logic              mbr_to_ir,
  input logic              clr_ie,
  input logic              step_clr
);

  // R1: state held at fetch step 1 until release completes
  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_done |-> (cycle_code == 2'b00 && tstep == STEP_W'(1)));

  // R2: fetch read is preceded by the address transfer
  a_r2_addr_before_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_code == 2'b00 && mem_rd) |-> $past(pc_to_mar));

  // R2: IR is loaded from an MBR filled in an earlier step
  a_r2_mbr_before_ir: assert property (@(posedge clk) disable iff (!rst_n)
    mbr_to_ir |-> (!mem_rd && $past(mbr_ld)));

  // R11: restart returns the counter to step 1
  a_r11_step_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_done && step_clr) |=> (tstep == STEP_W'(1)));

  // R11: otherwise the counter advances by one
  a_r11_step_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_done && !step_clr) |=> (tstep == STEP_W'($past(tstep) + 1'b1)));

  // R9: enabled pending interrupt after execute enters interrupt phase
  a_r9_irq_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_done && cycle_code == 2'b10 && step_clr && irq_req && irq_en)
    |=> (cycle_code == 2'b11));

  // R9: no enabled request after execute returns to fetch
  a_r9_back_to_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_done && cycle_code == 2'b10 && step_clr && !(irq_req && irq_en))
    |=> (cycle_code == 2'b00));

  // R10: interrupt phase fits in two steps and alone clears the enable
  a_r10_intr_short: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_code == 2'b11) |-> (tstep <= STEP_W'(2)));

  a_r10_clr_ie_in_intr: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ie |-> (cycle_code == 2'b11));

  // R5: ALU arithmetic selects appear only during execute
  a_r5_alu_in_exec: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_fn != 2'b00) |-> (cycle_code == 2'b10));

endmodule

bind cyc_ctrl_unit cyc_ctrl_chk #(
  .STEP_W (STEP_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_done   (rst_done),
  .irq_req    (irq_req),
  .irq_en     (irq_en),
  .cycle_code (cycle_code),
  .tstep      (tstep),
  .alu_fn     (alu_fn),
  .pc_to_mar  (ctl[cyc_ctrl_pkg::CL_PC_TO_MAR]),
  .mem_rd     (ctl[cyc_ctrl_pkg::CL_MEM_RD]),
  .mbr_ld     (ctl[cyc_ctrl_pkg::CL_MBR_LD]),
  .mbr_to_ir  (ctl[cyc_ctrl_pkg::CL_MBR_TO_IR]),
  .clr_ie     (ctl[cyc_ctrl_pkg::CL_CLR_IE]),
  .step_clr   (ctl[cyc_ctrl_pkg::CL_STEP_CLR])
);

// File: tb/cyc_ctrl_unit_bench.sv
`timescale 1ns/1ps
module cyc_ctrl_unit_bench;

  // Control bit values taken from the requirement bit map
  localparam logic [15:0] B_PC2MAR  = 16'h0001;
  localparam logic [15:0] B_RD      = 16'h0002;
  localparam logic [15:0] B_MBRLD   = 16'h0004;
  localparam logic [15:0] B_PCINC   = 16'h0008;
  localparam logic [15:0] B_MBR2IR  = 16'h0010;
  localparam logic [15:0] B_IRA2MAR = 16'h0020;
  localparam logic [15:0] B_MBR2IRA = 16'h0040;
  localparam logic [15:0] B_WR      = 16'h0080;
  localparam logic [15:0] B_PC2MBR  = 16'h0100;
  localparam logic [15:0] B_SAV2MAR = 16'h0200;
  localparam logic [15:0] B_VEC2PC  = 16'h0400;
  localparam logic [15:0] B_CLRIE   = 16'h0800;
  localparam logic [15:0] B_ACCLD   = 16'h1000;
  localparam logic [15:0] B_ALU2MBR = 16'h2000;
  localparam logic [15:0] B_IRA2PC  = 16'h4000;
  localparam logic [15:0] B_CLR     = 16'h8000;
  localparam logic [5:0]  SAVE_ADDR = 6'd60;
  localparam logic [11:0] HANDLER   = 12'd40;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        irq_req;
  logic [1:0]  cycle_code;
  logic [2:0]  tstep;
  logic [15:0] ctl;
  logic [1:0]  alu_fn;

  // Behavioural datapath
  logic [15:0] mem [0:63];
  logic [11:0] pc;
  logic [5:0]  mar;
  logic [15:0] mbr, ir, ac, alu_out, alu_s;
  logic        ie;
  logic [15:0] ctl_s;
  logic [15:0] ir_view;
  logic        alu_zero;
  int          rel_cnt;
  bit          loaded = 1'b0;

  always #10 clk = ~clk;

  always_comb begin
    case (alu_fn)
      2'b01:   alu_out = ac + mbr;
      2'b10:   alu_out = mbr + 16'd1;
      default: alu_out = mbr;
    endcase
  end
  assign alu_zero = (alu_out == 16'd0);
  assign ir_view  = (cycle_code == 2'b00 && tstep == 3'd3) ? mbr : ir;

  cyc_ctrl_unit u_cyc_ctrl_unit (
    .clk         (clk),
    .rst_n       (rst_n),
    .ir_opcode   (ir_view[14:12]),
    .ir_indirect (ir_view[15]),
    .alu_zero    (alu_zero),
    .irq_req     (irq_req),
    .irq_en      (ie),
    .cycle_code  (cycle_code),
    .tstep       (tstep),
    .ctl         (ctl),
    .alu_fn      (alu_fn)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      if (!loaded) begin
        for (int i = 0; i < 64; i++) mem[i] <= 16'h0000;
        mem[0]  <= 16'h1014;  // add 20
        mem[1]  <= 16'h9015;  // add indirect 21
        mem[2]  <= 16'h2017;  // isz 23
        mem[3]  <= 16'h2017;  // isz 23 (reaches zero, skips 4)
        mem[4]  <= 16'h1014;  // skipped
        mem[5]  <= 16'h7000;  // other opcode
        mem[6]  <= 16'h301E;  // bsa 30
        mem[20] <= 16'h0005;
        mem[21] <= 16'h0016;
        mem[22] <= 16'h0007;
        mem[23] <= 16'hFFFE;
        mem[24] <= 16'h0019;
        mem[25] <= 16'hFFFF;
        mem[31] <= 16'h1014;  // add 20
        mem[40] <= 16'hA018;  // isz indirect 24
        loaded  <= 1'b1;
      end
      pc <= '0; mar <= '0; mbr <= '0; ir <= '0; ac <= '0; ie <= 1'b1;
      rel_cnt <= 0;
    end else begin
      if (rel_cnt < 2) rel_cnt <= rel_cnt + 1;
      if (ctl_s[0]) mar <= pc[5:0];
      if (ctl_s[5]) mar <= ir[5:0];
      if (ctl_s[9]) mar <= SAVE_ADDR;
      if (ctl_s[1] && ctl_s[2]) mbr <= mem[mar];
      if (ctl_s[8]) mbr <= {4'h0, pc};
      if (ctl_s[13]) mbr <= alu_s;
      if (ctl_s[7]) mem[mar] <= mbr;
      if (ctl_s[10]) pc <= HANDLER;
      else if (ctl_s[14]) pc <= ir[11:0];
      else if (ctl_s[3]) pc <= pc + 12'd1;
      if (ctl_s[4]) ir <= mbr;
      if (ctl_s[6]) ir[11:0] <= mbr[11:0];
      if (ctl_s[12]) ac <= alu_s;
      if (ctl_s[11]) ie <= 1'b0;
    end
  end

  // Reference model: one queued expectation per step of the current phase
  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;
  logic [15:0] qw[$];
  logic [1:0]  qf[$];
  bit          qs[$];
  string       qr[$];
  int          m_phase = 0;
  int          m_step  = 1;
  string       m_ptag  = "R1";
  logic [15:0] exp_w;

  task automatic check_eq(input string tag, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] w, input logic [1:0] f,
                      input bit s, input string r);
    qw.push_back(w); qf.push_back(f); qs.push_back(s); qr.push_back(r);
  endtask

  task automatic build(input int ph);
    case (ph)
      0: begin
        push(B_PC2MAR, 2'b00, 0, "R2");
        push(B_RD | B_MBRLD | B_PCINC, 2'b00, 0, "R2");
        push(B_MBR2IR | B_CLR, 2'b00, 0, "R2");
      end
      1: begin
        push(B_IRA2MAR, 2'b00, 0, "R4");
        push(B_RD | B_MBRLD, 2'b00, 0, "R4");
        push(B_MBR2IRA | B_CLR, 2'b00, 0, "R4");
      end
      2: begin
        case (ir_view[14:12])
          3'd1: begin
            push(B_IRA2MAR, 2'b00, 0, "R5");
            push(B_RD | B_MBRLD, 2'b00, 0, "R5");
            push(B_ACCLD | B_CLR, 2'b01, 0, "R5");
          end
          3'd2: begin
            push(B_IRA2MAR, 2'b00, 0, "R6");
            push(B_RD | B_MBRLD, 2'b00, 0, "R6");
            push(B_ALU2MBR, 2'b10, 0, "R6");
            push(B_WR | B_CLR, 2'b00, 1, "R6");
          end
          3'd3: begin
            push(B_IRA2MAR | B_PC2MBR, 2'b00, 0, "R7");
            push(B_WR | B_IRA2PC, 2'b00, 0, "R7");
            push(B_PCINC | B_CLR, 2'b00, 0, "R7");
          end
          default: push(B_CLR, 2'b00, 0, "R8");
        endcase
      end
      default: begin
        push(B_PC2MBR | B_SAV2MAR | B_VEC2PC, 2'b00, 0, "R10");
        push(B_WR | B_CLRIE | B_CLR, 2'b00, 0, "R10");
      end
    endcase
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (!(rst_n && rel_cnt >= 2)) begin
        check_eq("R1", "cycle_code", 32'(cycle_code), 32'd0);
        check_eq("R1", "tstep", 32'(tstep), 32'd1);
        check_eq("R1", "ctl", 32'(ctl), 32'd0);
        check_eq("R1", "alu_fn", 32'(alu_fn), 32'd0);
        qw.delete(); qf.delete(); qs.delete(); qr.delete();
        m_phase = 0; m_step = 1; m_ptag = "R1";
      end else begin
        if (qw.size() == 0) build(m_phase);
        exp_w = qw[0] | ((qs[0] && alu_zero) ? B_PCINC : 16'h0000);
        check_eq(m_ptag, "cycle_code", 32'(cycle_code), 32'(m_phase));
        check_eq("R11", "tstep", 32'(tstep), 32'(m_step));
        check_eq(qr[0], "ctl", 32'(ctl), 32'(exp_w));
        check_eq(qr[0], "alu_fn", 32'(alu_fn), 32'(qf[0]));
        qw.delete(0); qf.delete(0); qs.delete(0); qr.delete(0);
        m_step++;
        if (qw.size() == 0) begin
          m_step = 1;
          case (m_phase)
            0: begin m_phase = ir_view[15] ? 1 : 2; m_ptag = "R3"; end
            1: begin m_phase = 2; m_ptag = "R4"; end
            2: begin m_phase = (irq_req && ie) ? 3 : 0; m_ptag = "R9"; end
            default: begin m_phase = 0; m_ptag = "R10"; end
          endcase
        end
      end
    end
    ctl_s = ctl;
    alu_s = alu_out;
  end

  initial begin
    rst_n   = 1'b0;
    irq_req = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    wait (pc == 12'd32);
    @(posedge clk); #1 irq_req = 1'b1;
    repeat (60) @(posedge clk);
    #1 irq_req = 1'b0;
    repeat (20) @(posedge clk);
    #1;
    check_eq("R5", "accumulator", 32'(ac), 32'd17);
    check_eq("R6", "mem[23] after two increments", 32'(mem[23]), 32'd0);
    check_eq("R6", "mem[25] via indirect increment", 32'(mem[25]), 32'd0);
    check_eq("R7", "saved return address", 32'(mem[30]), 32'd7);
    check_eq("R10", "interrupted PC saved", 32'(mem[60]), 32'd32);
    check_eq("R10", "interrupt enable cleared", 32'(ie), 32'd0);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (80) @(posedge clk);
    #1;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    #(20 * 50000);
    if (!done) begin
      done = 1'b1;
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

endmodule